// File: doc/BRIEF.md
# In-Order Retirement Order Manager

The block keeps decoded operations in a first-in, first-out order buffer so that results leave for the register file in program order, even when the execution units finish out of order. Each entry records which unit will produce the result, one bit per unit. It also records a jump/branch marker, a marker for operations that need no unit result, two destination write flags and the two destination register indices.

The oldest entry decides which unit's completion counts. It drives the execute-valid output and the per-unit writeback grants. When the control logic advances writeback, the oldest entry retires. The block then issues a one-cycle write pulse for the first destination register. When the entry carries a second destination, as a 64-bit result does, the block holds a split flag and issues the second write pulse one cycle after the first. The control logic uses the split flag to stall until that second write has finished.

Top module: `order_mgr`

## Requirements
- R1: An entry is stored on a clock edge where push_i and push_ready_o are both high. wrbk_adv_i retires the oldest entry. Entries retire in the order they were pushed, so the register index presented on wb_d1_idx_o follows push order.
- R2: The unit tag bit positions are: 0 single-cycle ALU, 1 divide, 2 multiply, 3 FP arithmetic, 4 FP compare, 5 load/store.
  - exec_valid_o is high for an oldest entry in three cases: its direct flag is set; its ALU tag is set without the branch flag and unit_valid_i[0] is high; its ALU tag and branch flag are set and jb_attr_valid_i is high.
  - It is also high when any other tag bit set in the oldest entry has its unit_valid_i bit high.
  - exec_valid_o is low when the buffer is empty.
- R3: grant_o equals the unit tag of the oldest entry, and is zero when the buffer is empty.
- R4: wb_d1_we_o is high for exactly the one cycle after a writeback advance whose retired entry had its first-write flag set, with that entry's first index on wb_d1_idx_o. It is low in every other cycle.
- R5: After a writeback advance whose retired entry had its second-write flag set, the following happens over three cycles:
  - In the next cycle, split_o is high.
  - In the cycle after that, wb_d2_we_o is high for one cycle with the entry's second index on wb_d2_idx_o.
  - In the cycle after that, split_o and wb_d2_we_o are both low.
- R6: split_o is high from the cycle after such an advance through the cycle of the second write. The control logic must not raise wrbk_adv_i while split_o is high, and may raise it only while exec_valid_o is high.
- R7: While rst_ni is low, the block is held as follows: empty_o is high, full_o is low, and wb_d1_we_o, wb_d2_we_o, split_o, exec_valid_o and grant_o are all low.
- R8: full_o is high when DEPTH entries are held. push_ready_o is the inverse of full_o. A push while full is ignored and leaves the contents and the retirement order unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| push_i | input | 1 | Enqueue a decoded operation |
| push_unit_i | input | 6 | One-hot unit tag of the new entry |
| push_jb_i | input | 1 | New entry is a jump/branch |
| push_direct_i | input | 1 | New entry needs no unit result |
| push_d1_we_i | input | 1 | New entry writes a first destination |
| push_d2_we_i | input | 1 | New entry writes a second destination |
| push_d1_idx_i | input | 5 | First destination index |
| push_d2_idx_i | input | 5 | Second destination index |
| push_ready_o | output | 1 | Buffer can take a push |
| full_o | output | 1 | Buffer holds DEPTH entries |
| empty_o | output | 1 | Buffer holds no entries |
| unit_valid_i | input | 6 | Per-unit result valid |
| jb_attr_valid_i | input | 1 | Branch attributes valid |
| exec_valid_o | output | 1 | Oldest entry's result is ready |
| grant_o | output | 6 | Per-unit writeback grant |
| wrbk_adv_i | input | 1 | Writeback advance; retires oldest entry |
| wb_d1_we_o | output | 1 | First register-file write pulse |
| wb_d1_idx_o | output | 5 | First write index |
| wb_d2_we_o | output | 1 | Second register-file write pulse |
| wb_d2_idx_o | output | 5 | Second write index |
| split_o | output | 1 | Second write pending; stall |

## Verification
The assertions assume a well-behaved control partner. It raises wrbk_adv_i only while exec_valid_o is high and never while split_o is high. The second-write sequence checks also rely on no advance arriving during a split. The stimulus meets these assumptions by deriving the advance from the bench's own predicted execute-valid and split state in the same cycle, and only then drawing a random choice. Unit valids, pushes (including pushes against a full buffer) and entry contents are otherwise random, with phases that fill the buffer, drain it, and favour double-write entries.

// File: rtl/order_mgr_pkg.sv
package order_mgr_pkg;
  localparam int NUM_UNITS = 6;
  localparam int REG_AW    = 5;

  localparam int U_ALU = 0;
  localparam int U_DIV = 1;
  localparam int U_MUL = 2;
  localparam int U_FPA = 3;
  localparam int U_FPC = 4;
  localparam int U_LSU = 5;

  typedef struct packed {
    logic [NUM_UNITS-1:0] unit;
    logic                 jb;
    logic                 direct;
    logic                 d1_we;
    logic                 d2_we;
    logic [REG_AW-1:0]    d1_idx;
    logic [REG_AW-1:0]    d2_idx;
  } ord_entry_t;
endpackage

// File: rtl/order_fifo.sv
module order_fifo
  import order_mgr_pkg::*;
#(
  parameter int DEPTH = 8
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       push_i,
  input  logic       pop_i,
  input  ord_entry_t din_i,
  output ord_entry_t head_o,
  output logic       full_o,
  output logic       empty_o
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  ord_entry_t      mem_q [DEPTH];
  logic [PW-1:0]   wr_q, rd_q;
  logic [CW-1:0]   cnt_q;
  logic            do_push, do_pop;

  function automatic logic [PW-1:0] ptr_inc(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full_o  = (cnt_q == CW'(DEPTH));
  assign empty_o = (cnt_q == '0);
  assign do_push = push_i & ~full_o;
  assign do_pop  = pop_i & ~empty_o;
  assign head_o  = mem_q[rd_q];

  always_ff @(posedge clk_i) begin
    if (do_push) mem_q[wr_q] <= din_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (do_push) wr_q <= ptr_inc(wr_q);
      if (do_pop)  rd_q <= ptr_inc(rd_q);
      case ({do_push, do_pop})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: ;
      endcase
    end
  end

  // R8
  ignored_push_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && full_o && !pop_i) |=> (cnt_q == $past(cnt_q)));

  // R1
  retire_count_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i && !empty_o && !push_i) |=> (cnt_q == $past(cnt_q) - 1'b1));
endmodule

// File: rtl/head_match.sv
module head_match
  import order_mgr_pkg::*;
(
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  ord_entry_t           head_i,
  input  logic                 empty_i,
  input  logic [NUM_UNITS-1:0] unit_valid_i,
  input  logic                 jb_attr_valid_i,
  output logic                 exec_valid_o,
  output logic [NUM_UNITS-1:0] grant_o
);
  logic [NUM_UNITS-1:0] hit;
  logic                 jb_hit;

  for (genvar u = 0; u < NUM_UNITS; u++) begin : g_hit
    if (u == U_ALU) begin : g_alu
      assign hit[u] = head_i.unit[u] & ~head_i.jb & unit_valid_i[u];
    end else begin : g_unit
      assign hit[u] = head_i.unit[u] & unit_valid_i[u];
    end
  end

  assign jb_hit       = head_i.unit[U_ALU] & head_i.jb & jb_attr_valid_i;
  assign exec_valid_o = ~empty_i & ((|hit) | jb_hit | head_i.direct);
  assign grant_o      = empty_i ? '0 : head_i.unit;

  // R3
  grant_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(grant_o));

  // R2
  valid_source_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exec_valid_o |-> (head_i.direct || (|(grant_o & unit_valid_i)) || jb_attr_valid_i));
endmodule

// File: rtl/wb_pulse.sv
module wb_pulse
  import order_mgr_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              adv_i,
  input  ord_entry_t        head_i,
  output logic              d1_we_o,
  output logic [REG_AW-1:0] d1_idx_o,
  output logic              d2_we_o,
  output logic [REG_AW-1:0] d2_idx_o,
  output logic              split_o
);
  logic              d1_we_q, d2_we_q, pend_q;
  logic [REG_AW-1:0] d1_idx_q, d2_idx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      d1_we_q  <= 1'b0;
      d1_idx_q <= '0;
    end else begin
      d1_we_q <= adv_i & head_i.d1_we;
      if (adv_i) d1_idx_q <= head_i.d1_idx;
    end
  end

  // second write trails the first by one cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      d2_we_q  <= 1'b0;
      pend_q   <= 1'b0;
      d2_idx_q <= '0;
    end else if (d2_we_q) begin
      d2_we_q <= 1'b0;
      pend_q  <= 1'b0;
    end else if (pend_q) begin
      d2_we_q <= 1'b1;
    end else if (adv_i) begin
      pend_q   <= head_i.d2_we;
      d2_idx_q <= head_i.d2_idx;
    end
  end

  assign d1_we_o  = d1_we_q;
  assign d1_idx_o = d1_idx_q;
  assign d2_we_o  = d2_we_q;
  assign d2_idx_o = d2_idx_q;
  assign split_o  = pend_q;

  // R4
  d1_after_adv_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    d1_we_q |-> $past(adv_i));

  // R5
  d2_follows_pend_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    d2_we_q |-> ($past(pend_q) && !$past(d2_we_q)));

  // R5
  d2_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    d2_we_q |=> (!d2_we_q && !pend_q));

  // R6
  no_adv_in_split_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pend_q |-> !adv_i);
endmodule

// File: rtl/order_mgr.sv
module order_mgr
  import order_mgr_pkg::*;
#(
  parameter int DEPTH = 8
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 push_i,
  input  logic [NUM_UNITS-1:0] push_unit_i,
  input  logic                 push_jb_i,
  input  logic                 push_direct_i,
  input  logic                 push_d1_we_i,
  input  logic                 push_d2_we_i,
  input  logic [REG_AW-1:0]    push_d1_idx_i,
  input  logic [REG_AW-1:0]    push_d2_idx_i,
  output logic                 push_ready_o,
  output logic                 full_o,
  output logic                 empty_o,
  input  logic [NUM_UNITS-1:0] unit_valid_i,
  input  logic                 jb_attr_valid_i,
  output logic                 exec_valid_o,
  output logic [NUM_UNITS-1:0] grant_o,
  input  logic                 wrbk_adv_i,
  output logic                 wb_d1_we_o,
  output logic [REG_AW-1:0]    wb_d1_idx_o,
  output logic                 wb_d2_we_o,
  output logic [REG_AW-1:0]    wb_d2_idx_o,
  output logic                 split_o
);
  ord_entry_t din, head;
  logic       full, empty, retire;

  assign din.unit   = push_unit_i;
  assign din.jb     = push_jb_i;
  assign din.direct = push_direct_i;
  assign din.d1_we  = push_d1_we_i;
  assign din.d2_we  = push_d2_we_i;
  assign din.d1_idx = push_d1_idx_i;
  assign din.d2_idx = push_d2_idx_i;

  assign retire = wrbk_adv_i & ~empty;

  order_fifo #(.DEPTH(DEPTH)) u_fifo (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (push_i),
    .pop_i   (wrbk_adv_i),
    .din_i   (din),
    .head_o  (head),
    .full_o  (full),
    .empty_o (empty)
  );

  head_match u_match (
    .clk_i           (clk_i),
    .rst_ni          (rst_ni),
    .head_i          (head),
    .empty_i         (empty),
    .unit_valid_i    (unit_valid_i),
    .jb_attr_valid_i (jb_attr_valid_i),
    .exec_valid_o    (exec_valid_o),
    .grant_o         (grant_o)
  );

  wb_pulse u_wb (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .adv_i    (retire),
    .head_i   (head),
    .d1_we_o  (wb_d1_we_o),
    .d1_idx_o (wb_d1_idx_o),
    .d2_we_o  (wb_d2_we_o),
    .d2_idx_o (wb_d2_idx_o),
    .split_o  (split_o)
  );

  assign full_o       = full;
  assign empty_o      = empty;
  assign push_ready_o = ~full;

  // R6
  adv_needs_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wrbk_adv_i |-> exec_valid_o);
endmodule

// File: tb/order_mgr_test.sv
module order_mgr_test;
  localparam int DEPTH = 8;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       push_i = 1'b0;
  logic [5:0] push_unit_i = '0;
  logic       push_jb_i = 1'b0, push_direct_i = 1'b0;
  logic       push_d1_we_i = 1'b0, push_d2_we_i = 1'b0;
  logic [4:0] push_d1_idx_i = '0, push_d2_idx_i = '0;
  logic [5:0] unit_valid_i = '0;
  logic       jb_attr_valid_i = 1'b0;
  logic       wrbk_adv_i = 1'b0;
  logic       push_ready_o, full_o, empty_o, exec_valid_o;
  logic [5:0] grant_o;
  logic       wb_d1_we_o, wb_d2_we_o, split_o;
  logic [4:0] wb_d1_idx_o, wb_d2_idx_o;

  always #10 clk = ~clk;

  order_mgr #(.DEPTH(DEPTH)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .push_i(push_i), .push_unit_i(push_unit_i),
    .push_jb_i(push_jb_i), .push_direct_i(push_direct_i),
    .push_d1_we_i(push_d1_we_i), .push_d2_we_i(push_d2_we_i),
    .push_d1_idx_i(push_d1_idx_i), .push_d2_idx_i(push_d2_idx_i),
    .push_ready_o(push_ready_o), .full_o(full_o), .empty_o(empty_o),
    .unit_valid_i(unit_valid_i), .jb_attr_valid_i(jb_attr_valid_i),
    .exec_valid_o(exec_valid_o), .grant_o(grant_o), .wrbk_adv_i(wrbk_adv_i),
    .wb_d1_we_o(wb_d1_we_o), .wb_d1_idx_o(wb_d1_idx_o),
    .wb_d2_we_o(wb_d2_we_o), .wb_d2_idx_o(wb_d2_idx_o), .split_o(split_o)
  );

  typedef struct {
    bit [5:0] unit;
    bit       jb, direct, d1, d2;
    bit [4:0] i1, i2;
  } ref_ent_t;

  ref_ent_t q[$];
  bit       m_d1, m_d2, m_pend;
  bit [4:0] m_i1, m_i2;
  int       total = 0, bad = 0;

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s act=%0h exp=%0h t=%0t", req, what, act, exp, $time);
    end
  endtask

  function automatic ref_ent_t make_ent(int seq, int d2_pct);
    ref_ent_t e;
    int u = $urandom_range(0, 6);
    e.direct = (u == 6);
    e.unit   = (u == 6) ? 6'd0 : 6'(1 << u);
    e.jb     = (u == 0) && ($urandom_range(0, 2) == 0);
    e.d1     = $urandom_range(0, 9) != 0;
    e.d2     = $urandom_range(0, 99) < d2_pct;
    e.i1     = 5'(seq);
    e.i2     = ~5'(seq);
    return e;
  endfunction

  initial begin
    #(20 * 200000);
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int seq = 0;
    @(negedge clk);
    // R7 reset state
    chk("R7", "empty", empty_o, 1);
    chk("R7", "full", full_o, 0);
    chk("R7", "d1_we", wb_d1_we_o, 0);
    chk("R7", "d2_we", wb_d2_we_o, 0);
    chk("R7", "split", split_o, 0);
    chk("R7", "exec_valid", exec_valid_o, 0);
    chk("R7", "grant", grant_o, 0);
    @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);

    for (int cyc = 0; cyc < 4000; cyc++) begin
      int push_pct, adv_pct, d2_pct;
      bit exp_ev, adv, pushed;
      bit [5:0] exp_gr;
      ref_ent_t e, h;

      if (cyc < 1000)      begin push_pct = 50; adv_pct = 60; d2_pct = 20; end
      else if (cyc < 1400) begin push_pct = 85; adv_pct = 5;  d2_pct = 20; end
      else if (cyc < 2200) begin push_pct = 25; adv_pct = 90; d2_pct = 20; end
      else                 begin push_pct = 55; adv_pct = 70; d2_pct = 70; end

      // registered outputs against model
      chk("R4", "d1_we", wb_d1_we_o, m_d1);
      if (m_d1) chk("R1", "d1_idx order", wb_d1_idx_o, m_i1);
      chk("R5", "d2_we", wb_d2_we_o, m_d2);
      if (m_d2) chk("R5", "d2_idx", wb_d2_idx_o, m_i2);
      chk("R6", "split", split_o, m_pend);
      chk("R8", "full", full_o, q.size() == DEPTH);
      chk("R8", "push_ready", push_ready_o, q.size() != DEPTH);
      chk("R1", "empty", empty_o, q.size() == 0);

      // drive new inputs
      e = make_ent(seq, d2_pct);
      push_i          = $urandom_range(0, 99) < push_pct;
      push_unit_i     = e.unit;
      push_jb_i       = e.jb;
      push_direct_i   = e.direct;
      push_d1_we_i    = e.d1;
      push_d2_we_i    = e.d2;
      push_d1_idx_i   = e.i1;
      push_d2_idx_i   = e.i2;
      unit_valid_i    = 6'($urandom_range(0, 63));
      jb_attr_valid_i = $urandom_range(0, 1) != 0;
      wrbk_adv_i      = 1'b0;
      #1;

      exp_ev = 1'b0;
      exp_gr = '0;
      if (q.size() != 0) begin
        h = q[0];
        exp_gr = h.unit;
        if (h.direct) exp_ev = 1'b1;
        if (h.unit[0] && !h.jb && unit_valid_i[0]) exp_ev = 1'b1;
        if (h.unit[0] && h.jb && jb_attr_valid_i) exp_ev = 1'b1;
        for (int u = 1; u < 6; u++)
          if (h.unit[u] && unit_valid_i[u]) exp_ev = 1'b1;
      end
      chk("R2", "exec_valid", exec_valid_o, exp_ev);
      chk("R3", "grant", grant_o, exp_gr);

      adv = exp_ev && !m_pend && ($urandom_range(0, 99) < adv_pct);
      wrbk_adv_i = adv;

      // model state after the coming edge
      pushed = push_i && (q.size() < DEPTH);
      m_d1 = adv ? h.d1 : 1'b0;
      if (adv) m_i1 = h.i1;
      if (m_d2) begin
        m_d2 = 1'b0;
        m_pend = 1'b0;
      end else if (m_pend) begin
        m_d2 = 1'b1;
      end else if (adv) begin
        m_pend = h.d2;
        m_i2 = h.i2;
      end
      if (adv) void'(q.pop_front());
      if (pushed) begin
        q.push_back(e);
        seq++;
      end

      @(negedge clk);
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule